// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the control and status registers that a single-hart RISC-V core needs to run a small real-time kernel in machine mode only. It keeps four registers (machine status, trap vector, exception PC and trap cause). The 12-bit CSR address is decoded against just these four, so no full address-space array is built. The unit performs the three register-source CSR instructions: write, set bits and clear bits. Each one reads the old value and writes the new value of the same register within one instruction.

The core also tells the unit about an environment call or a machine-mode return. The unit then raises a redirect request with a target PC, which the core feeds into its existing next-PC multiplexer. An environment call is always taken. It saves the faulting PC and the cause code, and it redirects to the trap vector. A return redirects to the saved exception PC. Written values are stored exactly as given, with no per-field legalisation. The status register affects nothing else and only needs the right reset value.

Top module: `mcsr_unit`

## Requirements
- R1: After reset, reads return 0x00001800 from address 0x300 (status) and zero from 0x305 (trap vector), 0x341 (exception PC) and 0x342 (cause).
- R2: A CSR operation (op 2'b01 write, 2'b10 set, 2'b11 clear; 2'b00 means no access) shows the register's old value on the read port in the same cycle. The new value becomes visible from the next cycle on.
- R3: A write stores all 32 bits of the source value unchanged, with no field legalisation.
- R4: Set stores old OR source, and clear stores old AND NOT source.
- R5: When the source-is-x0 input is high, set and clear leave the register unchanged, but a write still stores the source value.
- R6: An access to any other address returns zero, raises the error output in that cycle and changes no register.
- R7: An environment call raises the redirect in that cycle with the trap vector as target. On the next cycle the exception PC holds the call's PC and the cause holds 11.
- R8: A return raises the redirect with the current exception PC as target and changes no register.
- R9: If an environment call and a CSR operation on the exception PC or cause come in the same cycle, the trap values are the ones stored.
- R10: If an environment call and a return come in the same cycle, the redirect target is the trap vector.
- R11: Without an environment call or return, the redirect output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_op | input | 2 | CSR operation: 00 none, 01 write, 10 set, 11 clear |
| csr_addr | input | 12 | CSR address |
| csr_src | input | 32 | Source operand value |
| csr_src_x0 | input | 1 | Source register is x0 |
| csr_rdata | output | 32 | Old value of the addressed CSR |
| csr_err | output | 1 | Access to an unimplemented address |
| ecall_i | input | 1 | Environment call retiring this cycle |
| ecall_pc | input | 32 | PC of the environment call |
| mret_i | input | 1 | Machine return retiring this cycle |
| redirect_o | output | 1 | Next-PC redirect request |
| redirect_pc | output | 32 | Redirect target |

## Verification
The hardest case to reach from the ports is a collision: a trap lands in the same cycle as a CSR write to the exception PC. Another is a call that arrives together with a return. The bench drives both together on purpose, with operand values that differ from the trap values. It then reads the registers back on later cycles. A run of vectors also builds up state in a fixed order. Each read therefore shows whether the earlier set, clear and x0-suppressed operations took effect.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int ADDR_W  = 12;
  localparam int NUM_CSR = 4;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam int IDX_STATUS = 0;
  localparam int IDX_TVEC   = 1;
  localparam int IDX_EPC    = 2;
  localparam int IDX_CAUSE  = 3;

  localparam logic [31:0] CAUSE_ECALL_M = 32'd11;

  function automatic logic [ADDR_W-1:0] csr_addr_of(input int idx);
    case (idx)
      IDX_STATUS: csr_addr_of = 12'h300;
      IDX_TVEC:   csr_addr_of = 12'h305;
      IDX_EPC:    csr_addr_of = 12'h341;
      default:    csr_addr_of = 12'h342;
    endcase
  endfunction

  function automatic logic [31:0] csr_reset_of(input int idx);
    csr_reset_of = (idx == IDX_STATUS) ? 32'h0000_1800 : 32'h0;
  endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CSR-1:0] sel,
  output logic               hit
);
  for (genvar i = 0; i < NUM_CSR; i++) begin : g_match
    assign sel[i] = (addr == csr_addr_of(i));
  end
  assign hit = |sel;
endmodule

// File: rtl/mcsr_alu.sv
module mcsr_alu
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op,
  input  logic [XLEN-1:0] src,
  input  logic            src_x0,
  input  logic [XLEN-1:0] old_val,
  input  logic            hit,
  output logic [XLEN-1:0] new_val,
  output logic            wr_en
);
  always_comb begin
    new_val = old_val;
    wr_en   = 1'b0;
    case (op)
      OP_WRITE: begin new_val = src;            wr_en = hit;           end
      OP_SET:   begin new_val = old_val | src;  wr_en = hit && !src_x0; end
      OP_CLEAR: begin new_val = old_val & ~src; wr_en = hit && !src_x0; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CSR-1:0]            wr_sel,
  input  logic                          wr_en,
  input  logic [XLEN-1:0]               wr_data,
  input  logic                          trap_en,
  input  logic [XLEN-1:0]               trap_pc,
  output logic [NUM_CSR-1:0][XLEN-1:0]  q
);
  for (genvar i = 0; i < NUM_CSR; i++) begin : g_reg
    logic [XLEN-1:0] d;
    logic            en;
    localparam logic [XLEN-1:0] RST = XLEN'(csr_reset_of(i));

    always_comb begin
      en = wr_en && wr_sel[i];
      d  = wr_data;
      if (trap_en && i == IDX_EPC) begin
        en = 1'b1;
        d  = trap_pc;
      end else if (trap_en && i == IDX_CAUSE) begin
        en = 1'b1;
        d  = XLEN'(CAUSE_ECALL_M);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= RST;
      else if (en) q[i] <= d;
    end
  end
endmodule

// File: rtl/mcsr_trap.sv
module mcsr_trap #(
  parameter int XLEN = 32
) (
  input  logic            ecall,
  input  logic            mret,
  input  logic [XLEN-1:0] tvec,
  input  logic [XLEN-1:0] epc,
  output logic            redirect,
  output logic [XLEN-1:0] target
);
  always_comb begin
    redirect = ecall || mret;
    if (ecall)     target = tvec;
    else if (mret) target = epc;
    else           target = '0;
  end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        csr_op,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_src,
  input  logic              csr_src_x0,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_err,
  input  logic              ecall_i,
  input  logic [XLEN-1:0]   ecall_pc,
  input  logic              mret_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  csr_op_e                         op;
  logic [NUM_CSR-1:0]              sel;
  logic                            hit;
  logic [NUM_CSR-1:0][XLEN-1:0]    regs;
  logic [XLEN-1:0]                 old_val;
  logic [XLEN-1:0]                 new_val;
  logic                            wr_en;
  logic [XLEN-1:0]                 csr_status, csr_tvec, csr_epc, csr_cause;

  assign op = csr_op_e'(csr_op);

  mcsr_decode u_dec (.addr(csr_addr), .sel(sel), .hit(hit));

  always_comb begin
    old_val = '0;
    for (int i = 0; i < NUM_CSR; i++)
      if (sel[i]) old_val = old_val | regs[i];
  end

  mcsr_alu #(.XLEN(XLEN)) u_alu (
    .op(op), .src(csr_src), .src_x0(csr_src_x0), .old_val(old_val),
    .hit(hit), .new_val(new_val), .wr_en(wr_en)
  );

  mcsr_file #(.XLEN(XLEN)) u_file (
    .clk(clk), .rst_n(rst_sync_n), .wr_sel(sel), .wr_en(wr_en),
    .wr_data(new_val), .trap_en(ecall_i), .trap_pc(ecall_pc), .q(regs)
  );

  assign csr_status = regs[IDX_STATUS];
  assign csr_tvec   = regs[IDX_TVEC];
  assign csr_epc    = regs[IDX_EPC];
  assign csr_cause  = regs[IDX_CAUSE];

  mcsr_trap #(.XLEN(XLEN)) u_trap (
    .ecall(ecall_i), .mret(mret_i), .tvec(csr_tvec), .epc(csr_epc),
    .redirect(redirect_o), .target(redirect_pc)
  );

  assign csr_rdata = (op != OP_NONE) ? old_val : '0;
  assign csr_err   = (op != OP_NONE) && !hit;
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ecall_i,
  input logic [XLEN-1:0] ecall_pc,
  input logic            mret_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc,
  input logic            csr_err,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] csr_status,
  input logic [XLEN-1:0] csr_tvec,
  input logic [XLEN-1:0] csr_epc,
  input logic [XLEN-1:0] csr_cause
);
  // R11
  no_spurious_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecall_i && !mret_i) |-> !redirect_o);

  // R7
  ecall_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecall_i |-> (redirect_o && redirect_pc == csr_tvec));

  // R7
  ecall_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecall_i |=> (csr_epc == $past(ecall_pc) && csr_cause == XLEN'(11)));

  // R8
  mret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !ecall_i) |-> (redirect_o && redirect_pc == csr_epc));

  // R8
  mret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !ecall_i && !csr_err && csr_rdata == '0) |=> $stable(csr_epc));

  // R6
  unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |-> (csr_rdata == '0));

  // R6
  unimpl_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_err && !ecall_i) |=> ($stable(csr_status) && $stable(csr_tvec)
                               && $stable(csr_epc) && $stable(csr_cause)));
endmodule

bind mcsr_unit mcsr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ecall_i(ecall_i), .ecall_pc(ecall_pc),
  .mret_i(mret_i), .redirect_o(redirect_o), .redirect_pc(redirect_pc),
  .csr_err(csr_err), .csr_rdata(csr_rdata), .csr_status(csr_status),
  .csr_tvec(csr_tvec), .csr_epc(csr_epc), .csr_cause(csr_cause)
);

// File: tb/mcsr_unit_tb.sv
module mcsr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  csr_op;
  logic [11:0] csr_addr;
  logic [31:0] csr_src;
  logic        csr_src_x0;
  logic [31:0] csr_rdata;
  logic        csr_err;
  logic        ecall_i;
  logic [31:0] ecall_pc;
  logic        mret_i;
  logic        redirect_o;
  logic [31:0] redirect_pc;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mcsr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_src(csr_src), .csr_src_x0(csr_src_x0), .csr_rdata(csr_rdata),
    .csr_err(csr_err), .ecall_i(ecall_i), .ecall_pc(ecall_pc),
    .mret_i(mret_i), .redirect_o(redirect_o), .redirect_pc(redirect_pc)
  );

  // {op, addr, src, src_x0, expected rdata, expected err}
  localparam int NV = 14;
  localparam logic [79:0] VEC [NV] = '{
    {2'b01, 12'h305, 32'h8000_0100, 1'b0, 32'h0000_0000, 1'b0}, // R3
    {2'b10, 12'h305, 32'h0000_0003, 1'b0, 32'h8000_0100, 1'b0}, // R2 R4
    {2'b11, 12'h305, 32'h0000_0001, 1'b0, 32'h8000_0103, 1'b0}, // R4
    {2'b10, 12'h305, 32'h0000_00FF, 1'b1, 32'h8000_0102, 1'b0}, // R5
    {2'b11, 12'h305, 32'hFFFF_FFFF, 1'b1, 32'h8000_0102, 1'b0}, // R5
    {2'b01, 12'h300, 32'h0000_0008, 1'b0, 32'h0000_1800, 1'b0}, // R3
    {2'b10, 12'h300, 32'h0000_1800, 1'b0, 32'h0000_0008, 1'b0}, // R4
    {2'b01, 12'h341, 32'h0000_1234, 1'b0, 32'h0000_0000, 1'b0}, // R3
    {2'b01, 12'h342, 32'hDEAD_BEEF, 1'b0, 32'h0000_0000, 1'b0}, // R3
    {2'b11, 12'h342, 32'hFFFF_0000, 1'b0, 32'hDEAD_BEEF, 1'b0}, // R4
    {2'b01, 12'h344, 32'h0000_0005, 1'b0, 32'h0000_0000, 1'b1}, // R6
    {2'b10, 12'h342, 32'h0000_0000, 1'b0, 32'h0000_BEEF, 1'b0}, // R2
    {2'b01, 12'h300, 32'h0000_0000, 1'b1, 32'h0000_1808, 1'b0}, // R5
    {2'b10, 12'h300, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    csr_op = 2'b00; csr_addr = '0; csr_src = '0; csr_src_x0 = 1'b0;
    ecall_i = 1'b0; ecall_pc = '0; mret_i = 1'b0;
  endtask

  // drive after falling edge, sample 1 ns later, then take the rising edge
  task automatic access(input logic [1:0] op, input logic [11:0] a, input logic [31:0] s,
                        input logic x0, input logic [31:0] exp_rd, input logic exp_err,
                        input string req);
    @(negedge clk);
    csr_op = op; csr_addr = a; csr_src = s; csr_src_x0 = x0;
    #1;
    check(req, csr_rdata, exp_rd);
    check(req, {31'b0, csr_err}, {31'b0, exp_err});
    @(posedge clk);
    #0.5 idle();
  endtask

  task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string req);
    access(2'b10, a, 32'h0, 1'b1, exp, 1'b0, req);
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset values
    peek(12'h300, 32'h0000_1800, "R1");
    peek(12'h305, 32'h0, "R1");
    peek(12'h341, 32'h0, "R1");
    peek(12'h342, 32'h0, "R1");

    // R11 quiet redirect
    @(negedge clk); #1;
    check("R11", {31'b0, redirect_o}, 32'h0);

    for (int i = 0; i < NV; i++)
      access(VEC[i][79:78], VEC[i][77:66], VEC[i][65:34], VEC[i][33],
             VEC[i][32:1], VEC[i][0], "R2-R6 vector");

    // R6 unimplemented write left registers untouched
    peek(12'h341, 32'h0000_1234, "R6");
    access(2'b11, 12'hF14, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1, "R6");

    // R7 environment call
    @(negedge clk);
    ecall_i = 1'b1; ecall_pc = 32'h0000_2000;
    #1;
    check("R7", {31'b0, redirect_o}, 32'h1);
    check("R7", redirect_pc, 32'h8000_0102);
    @(posedge clk); #0.5 idle();
    peek(12'h341, 32'h0000_2000, "R7");
    peek(12'h342, 32'd11, "R7");

    // R8 return
    @(negedge clk);
    mret_i = 1'b1;
    #1;
    check("R8", {31'b0, redirect_o}, 32'h1);
    check("R8", redirect_pc, 32'h0000_2000);
    @(posedge clk); #0.5 idle();
    peek(12'h341, 32'h0000_2000, "R8");
    peek(12'h342, 32'd11, "R8");

    // R9 trap beats CSR write to exception PC, then to cause
    @(negedge clk);
    ecall_i = 1'b1; ecall_pc = 32'h0000_3000;
    csr_op = 2'b01; csr_addr = 12'h341; csr_src = 32'h0000_0999;
    @(posedge clk); #0.5 idle();
    peek(12'h341, 32'h0000_3000, "R9");
    @(negedge clk);
    ecall_i = 1'b1; ecall_pc = 32'h0000_3004;
    csr_op = 2'b01; csr_addr = 12'h342; csr_src = 32'h0000_0777;
    @(posedge clk); #0.5 idle();
    peek(12'h342, 32'd11, "R9");

    // R10 call and return together
    @(negedge clk);
    ecall_i = 1'b1; mret_i = 1'b1; ecall_pc = 32'h0000_4000;
    #1;
    check("R10", redirect_pc, 32'h8000_0102);
    @(posedge clk); #0.5 idle();
    peek(12'h341, 32'h0000_4000, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule